// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that exposes a small bank of 8-bit registers to an external host through a register pointer. The host addresses the block with a control byte (seven address bits, then the read/write bit, most significant bit first). In the write direction the first byte after the control byte loads the pointer, and any later bytes are stored at the register it selects. To read, the host sets the pointer with a write-direction transfer. It then issues a Start or repeated Start and a control byte with the read bit set. The block then shifts out the register the pointer selects.

A mode input chooses how the pointer behaves after each data byte. In sequential mode it advances and wraps back to zero after the last register. In byte mode it stays put, so repeated bytes access the same register. SCL and SDA pass through a synchroniser and are oversampled by the system clock. The block drives SDA open-drain: `sda_oe` high means the line is pulled low.

The chip side reaches the same registers through a local port. Writes use a valid/ready handshake and reads are combinational. A local write is accepted in any cycle where `lw_valid` and `lw_ready` are both high. A write arriving over I2C owns the register bank for one cycle, and `lw_ready` is low in that cycle. A local writer must then hold `lw_valid`, `lw_addr` and `lw_data` steady until it sees ready.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges a control byte (SDA held low through the ninth clock) only when bits 7..1 equal `DEV_ADDR`. After any other address it does not drive SDA until the next Start.
- R2: In the write direction, the byte after the control byte loads the pointer, and a following data byte is stored in the register the pointer selects. The stored value is visible on `lr_data`.
- R3: With `seq_mode` = 1, each write data byte goes to the current pointer, and the pointer then advances by one.
- R4: In sequential mode, a pointer at or beyond `NUM_REGS`-1 advances to zero. This holds for reads and for writes.
- R5: With `seq_mode` = 0, the pointer does not move after a data byte, so repeated bytes write or read the same register.
- R6: After a Start or repeated Start and a control byte with bit 0 = 1, the block shifts out the selected register MSB first. The pointer keeps its value across a Stop.
- R7: During a sequential read, the pointer advances after every transmitted byte. When the host acknowledges (SDA low), the next byte comes from the advanced pointer.
- R8: When the host does not acknowledge a read byte (SDA high), the block releases SDA and goes idle. Bytes clocked after that, before a new Start, read as 0xFF.
- R9: Writes to a pointer value of `NUM_REGS` or above change no register. Reads from such a value return 0x00.
- R10: `sda_oe` rises only while the synchronised SCL is low.
- R11: `lw_ready` is low exactly in the cycle an I2C write commits. Accepted local writes are stored and appear on `lr_data` one cycle later.
- R12: After reset, `sda_oe` is 0, all registers are 0 and `lw_ready` is 1. A Stop returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 = pull SDA low |
| seq_mode | input | 1 | 1 = sequential pointer, 0 = byte mode |
| lw_valid | input | 1 | Local write request |
| lw_ready | output | 1 | Local write accepted when high with valid |
| lw_addr | input | 8 | Local write register index |
| lw_data | input | 8 | Local write data |
| lr_addr | input | 8 | Local read register index |
| lr_data | output | 8 | Register contents at `lr_addr`, 0 if out of range |

## Verification
The bench builds the block with `NUM_REGS` = 6 and `DEV_ADDR` = 0x27. With only six registers, a three- or four-byte sequential burst crosses the wrap from register 5 to 0 in both directions. Pointer values 7 and 9 fall outside the bank, so the ignored write and the zero read can be tested. The chosen address lets the bench send a neighbouring address (0x26) that differs only in the last address bit, to check that such a control byte is rejected.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CACK,
    ST_REG,
    ST_RACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RDACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 22,
  parameter int DW       = 8,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [DW-1:0] b_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_raddr,
  output logic [DW-1:0] b_rdata
);
  localparam int            IW   = $clog2(NUM_REGS);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  logic [NUM_REGS*DW-1:0] flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(g);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (a_we && a_waddr == IDX)  q <= a_wdata;
      else if (b_we && b_waddr == IDX)  q <= b_wdata;
    end
    assign flat[g*DW +: DW] = q;
  end

  always_comb begin
    a_rdata = '0;
    b_rdata = '0;
    if (a_raddr <= LAST) a_rdata = flat[a_raddr[IW-1:0]*DW +: DW];
    if (b_raddr <= LAST) b_rdata = flat[b_raddr[IW-1:0]*DW +: DW];
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter int         NUM_REGS = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       seq_mode,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rx_byte,
  output tgt_state_e state
);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  tgt_state_e st;
  logic [3:0] cnt;
  logic [7:0] rx, tx;
  logic       rw, mack;

  function automatic logic [7:0] step(input logic [7:0] p, input logic seq);
    if (!seq)          return p;
    else if (p >= LAST) return 8'h00;
    else               return p + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else if (start_det) begin
        st  <= ST_CTRL;
        cnt <= '0;
      end else if (scl_rise) begin
        case (st)
          ST_CTRL, ST_REG, ST_WR: begin
            rx  <= {rx[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          ST_RD:    cnt  <= cnt + 4'd1;
          ST_RDACK: mack <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_CTRL: if (cnt == 4'd8) begin
            cnt <= '0;
            if (rx[7:1] == DEV_ADDR) begin
              st <= ST_CACK;
              rw <= rx[0];
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_CACK: begin
            if (rw) begin
              st <= ST_RD;
              tx <= rd_data;
            end else begin
              st <= ST_REG;
            end
          end
          ST_REG: if (cnt == 4'd8) begin
            cnt <= '0;
            ptr <= rx;
            st  <= ST_RACK;
          end
          ST_RACK: st <= ST_WR;
          ST_WR: if (cnt == 4'd8) begin
            cnt     <= '0;
            wr_stb  <= 1'b1;
            wr_addr <= ptr;
            wr_data <= rx;
            ptr     <= step(ptr, seq_mode);
            st      <= ST_WACK;
          end
          ST_WACK: st <= ST_WR;
          ST_RD: begin
            if (cnt == 4'd8) begin
              cnt <= '0;
              ptr <= step(ptr, seq_mode);
              st  <= ST_RDACK;
            end else begin
              tx <= {tx[6:0], 1'b0};
            end
          end
          ST_RDACK: begin
            if (mack) begin
              st <= ST_RD;
              tx <= rd_data;
            end else begin
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      ST_CACK, ST_RACK, ST_WACK: sda_oe = 1'b1;
      ST_RD:                     sda_oe = ~tx[7];
      default:                   sda_oe = 1'b0;
    endcase
  end

  assign rx_byte = rx;
  assign state   = st;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         NUM_REGS    = 22,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       seq_mode,
  input  logic       lw_valid,
  output logic       lw_ready,
  input  logic [7:0] lw_addr,
  input  logic [7:0] lw_data,
  input  logic [7:0] lr_addr,
  output logic [7:0] lr_data
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wr_addr, wr_data, rx_byte, rd_data;
  logic       wr_stb;
  tgt_state_e st;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .seq_mode(seq_mode), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_byte(rx_byte), .state(st)
  );

  // bus-side write owns the bank in its commit cycle
  assign lw_ready = ~wr_stb;

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DW(8), .AW(8)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .a_we(wr_stb), .a_waddr(wr_addr), .a_wdata(wr_data),
    .b_we(lw_valid & lw_ready), .b_waddr(lw_addr), .b_wdata(lw_data),
    .a_raddr(ptr), .a_rdata(rd_data),
    .b_raddr(lr_addr), .b_rdata(lr_data)
  );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter int         NUM_REGS = 22
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input tgt_state_e st,
  input logic [7:0] rx_byte,
  input logic [7:0] ptr,
  input logic       wr_stb,
  input logic       lw_ready
);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  assert_ack_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CACK) |-> (rx_byte[7:1] == DEV_ADDR));

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && ($past(st) != ST_REG)) |-> (ptr <= LAST));

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  assert_port_yield_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !lw_ready);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(
  .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .st(st),
  .rx_byte(rx_byte), .ptr(ptr), .wr_stb(wr_stb), .lw_ready(lw_ready)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  localparam int         NREG = 6;
  localparam logic [6:0] DEV  = 7'h27;
  localparam int         Q    = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, seq_mode, lw_valid;
  logic [7:0] lw_addr, lw_data, lr_addr;
  wire        sda_oe, lw_ready;
  wire [7:0]  lr_data;
  wire        sda_line = sda_m & ~sda_oe;

  i2c_regfile_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .seq_mode(seq_mode), .lw_valid(lw_valid),
    .lw_ready(lw_ready), .lw_addr(lw_addr), .lw_data(lw_data),
    .lr_addr(lr_addr), .lr_data(lr_data)
  );

  int checks = 0, errors = 0, busy_cnt = 0, r10_bad = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  logic [7:0] mptr = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got;
  event       got_ev;
  logic       oe_prev = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares each byte the bus returns
  always @(got_ev) begin
    if (exp_q.size() == 0) check("unexpected byte", got, 8'hxx);
    else check(tag_q.pop_front(), got, exp_q.pop_front());
  end

  always @(negedge clk) begin
    if (!lw_ready) busy_cnt++;
    if (sda_oe && !oe_prev && scl_m) r10_bad++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] adv(input logic [7:0] p, input bit seq);
    if (!seq) return p;
    return (p >= 8'(NREG - 1)) ? 8'h00 : p + 8'd1;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] p);
    return (p < 8'(NREG)) ? model[p[2:0]] : 8'h00;
  endfunction

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_restart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack_n = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] b;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
    got = b;
    -> got_ev;
    tick(1);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bus_write(input bit seq, input logic [7:0] addr,
                           input logic [7:0] d [4], input int n, input string tag);
    logic a;
    seq_mode = seq;
    bus_start();
    send_byte({DEV, 1'b0}, a); check({tag, " ctl ack"}, {7'd0, a}, 8'h00);
    send_byte(addr, a);        check({tag, " reg ack"}, {7'd0, a}, 8'h00);
    mptr = addr;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a);      check({tag, " data ack"}, {7'd0, a}, 8'h00);
      if (mptr < 8'(NREG)) model[mptr[2:0]] = d[k];
      mptr = adv(mptr, seq);
    end
    bus_stop();
  endtask

  task automatic bus_read(input bit seq, input bit set_ptr, input logic [7:0] addr,
                          input int n, input string tag);
    logic a;
    seq_mode = seq;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, a); check({tag, " ctl ack"}, {7'd0, a}, 8'h00);
      send_byte(addr, a);        check({tag, " reg ack"}, {7'd0, a}, 8'h00);
      mptr = addr;
      bus_restart();
    end
    send_byte({DEV, 1'b1}, a);   check({tag, " rd ctl ack"}, {7'd0, a}, 8'h00);
    for (int k = 0; k < n; k++) begin
      expect_byte(mread(mptr), tag);
      mptr = adv(mptr, seq);
      recv_byte(k < n - 1);
    end
    bus_stop();
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < NREG; r++) begin
      lr_addr = 8'(r); tick(1);
      check(tag, lr_data, model[r]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    rst_n = 0; scl_m = 1; sda_m = 1; seq_mode = 0;
    lw_valid = 0; lw_addr = 0; lw_data = 0; lr_addr = 0;
    for (int r = 0; r < NREG; r++) model[r] = 8'h00;
    tick(5);
    check("R12 reset oe", {7'd0, sda_oe}, 8'h00);
    check("R12 reset ready", {7'd0, lw_ready}, 8'h01);
    rst_n = 1; tick(5);
    check_regs("R12 reset regs");

    // R11: preload through the local port
    for (int r = 0; r < NREG; r++) begin
      lw_valid = 1; lw_addr = 8'(r); lw_data = 8'hA0 + 8'(r); tick(1);
      model[r] = 8'hA0 + 8'(r);
    end
    lw_valid = 0; tick(1);
    check_regs("R11 local write");

    // R1: neighbouring address is ignored
    bus_start();
    send_byte({7'h26, 1'b0}, a); check("R1 wrong addr ack", {7'd0, a}, 8'h01);
    send_byte(8'h00, a);         check("R1 no drive after", {7'd0, a}, 8'h01);
    bus_stop();
    check_regs("R1 regs untouched");

    bus_write(0, 8'd2, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, "R2");
    check_regs("R2 regs");
    bus_write(0, 8'd3, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, "R5");
    check_regs("R5 byte-mode regs");
    bus_write(1, 8'd4, '{8'h44, 8'h55, 8'h66, 8'h00}, 3, "R3");
    check_regs("R3 R4 seq write wrap");

    bus_read(0, 1, 8'd2, 1, "R6");
    bus_read(0, 1, 8'd3, 3, "R5 read");
    bus_read(1, 1, 8'd4, 4, "R7 R4 seq read");
    bus_read(0, 0, 8'd0, 1, "R6 ptr kept");

    bus_write(1, 8'd9, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, "R9");
    check_regs("R9 regs untouched");
    bus_read(0, 1, 8'd7, 1, "R9 zero read");

    // R8: NACK then keep clocking without Stop
    seq_mode = 1;
    bus_start();
    send_byte({DEV, 1'b0}, a); check("R8 ctl ack", {7'd0, a}, 8'h00);
    send_byte(8'd5, a);        check("R8 reg ack", {7'd0, a}, 8'h00);
    bus_restart();
    send_byte({DEV, 1'b1}, a); check("R8 rd ctl ack", {7'd0, a}, 8'h00);
    expect_byte(model[5], "R8 last byte");
    recv_byte(0);
    expect_byte(8'hFF, "R8 released");
    recv_byte(0);
    bus_stop();
    tick(4);
    check("R12 idle after stop", {7'd0, sda_oe}, 8'h00);

    // R11: local write held during a bus write to the same register
    busy_cnt = 0;
    lw_valid = 1; lw_addr = 8'd1; lw_data = 8'hC3;
    bus_write(0, 8'd1, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, "R11 bus");
    tick(2); lw_valid = 0; tick(1);
    model[1] = 8'hC3;
    check("R11 busy cycles", 8'(busy_cnt), 8'd1);
    check_regs("R11 local wins after stall");

    check("R10 oe rise scl low", 8'(r10_bad), 8'd0);
    tick(20);
    check("scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule